// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block turns a small set of programmed timing values into the strobes that drive a raster LCD panel. From a core clock it derives a pixel clock, a line clock that marks horizontal sync, a frame clock that marks vertical sync, and a data-enable that is high only for visible pixels. While data-enable is high it also gives the column and row of the current pixel, so that a pixel fetch path downstream knows which word to present.

Each line is built from four pieces in a fixed order: sync, back porch, active, front porch. Each frame uses the same order, counted in whole lines. The visible width is programmed in steps of 16 pixels. The visible height comes from a low field and a separate top bit. The whole configuration is copied into the block while the raster is stopped and is then held for as long as the raster runs. When enable is dropped, the block does not stop at once. It finishes the frame in progress, returns to idle and raises a done flag.

Top module: `lcd_raster_timing`

## Requirements
- R1: The pixel period is max(cfg_div, 2) core clock cycles, so a divisor of 0 or 1 behaves as 2. A frame holds exactly one pixel-clock rising edge per pixel period.
- R2: Visible pixels per line equal (W+1)*16, where W = {cfg_width_top, cfg_width_lo} is a 7-bit value. Setting the top bit allows up to 2048 pixels. With EXT_WIDTH = 0 the top bit is taken as 0.
- R3: Visible lines per frame equal L+1, where L = {cfg_height_top, cfg_height_lo} is an 11-bit value.
- R4: A line lasts (cfg_hsync+1) + (cfg_hback+1) + visible pixels + (cfg_hfront+1) pixel periods, in the order sync, back porch, active, front porch. The line clock is asserted (before inversion) only during the sync part.
- R5: A frame lasts (cfg_vsync+1) + (cfg_vback+1) + visible lines + (cfg_vfront+1) lines, in the same order. The frame clock is asserted (before inversion) only during the sync lines. It rises in the first cycle after the raster starts.
- R6: de is high exactly during visible pixels of visible lines. h_pos and v_pos give the 0-based column and row while de is high and are 0 otherwise.
- R7: inv_pclk, inv_lclk and inv_fclk each invert their own output. In idle the three clock outputs sit at their inversion bit.
- R8: If enable is low in the last cycle of a frame, or was seen low at any earlier cycle of that frame, the raster stops when that frame ends. done rises in the next cycle and de stays low afterwards.
- R9: Configuration is captured only while stopped, in every idle cycle including the one in which enable is seen high. Changes made while running have no effect. Starting again clears done.
- R10: After reset the block is idle with de, done and all positions at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raster_en | input | 1 | Start the raster; clear it to request a stop at frame end |
| cfg_div | input | 8 | Pixel clock divisor |
| cfg_width_lo | input | 6 | Visible width code, low bits, in units of 16 pixels minus one |
| cfg_width_top | input | 1 | Visible width code, top bit |
| cfg_height_lo | input | 10 | Visible lines minus one, low bits |
| cfg_height_top | input | 1 | Visible lines minus one, top bit |
| cfg_hsync | input | 6 | Horizontal sync length minus one, in pixels |
| cfg_hback | input | 8 | Horizontal back porch minus one, in pixels |
| cfg_hfront | input | 8 | Horizontal front porch minus one, in pixels |
| cfg_vsync | input | 6 | Vertical sync length minus one, in lines |
| cfg_vback | input | 8 | Vertical back porch minus one, in lines |
| cfg_vfront | input | 8 | Vertical front porch minus one, in lines |
| inv_pclk | input | 1 | Invert the pixel clock |
| inv_lclk | input | 1 | Invert the line clock |
| inv_fclk | input | 1 | Invert the frame clock |
| pclk | output | 1 | Pixel clock |
| lclk | output | 1 | Line clock (horizontal sync) |
| fclk | output | 1 | Frame clock (vertical sync) |
| de | output | 1 | Visible data enable |
| h_pos | output | 11 | Visible column while de is high |
| v_pos | output | 11 | Visible row while de is high |
| done | output | 1 | Raster has stopped after a graceful disable |

## Verification
The stop request and the end of the frame can land in the same cycle. The bench drives enable low in exactly the last cycle of a frame, counted in core cycles from the frame clock rise. It then expects done one cycle later, with no new frame started. A second case drops enable one cycle later, in the first cycle of the next frame. There the bench expects the whole following frame to run and done to appear exactly one frame period later. Both outcomes are judged only at the ports, by cycle counts taken from the frame clock.

// File: rtl/lcdt_pkg.sv
// Package: shared field widths, the phase encoding and the captured
// configuration record for the raster timing generator.
// Assumes the active-column counter is the widest counter in the block.
package lcdt_pkg;

    localparam int DIV_W    = 8;
    localparam int PORCH_W  = 8;
    localparam int SYNC_W   = 6;
    localparam int PPL_LO_W = 6;
    localparam int PPL_W    = PPL_LO_W + 1;
    localparam int LPF_LO_W = 10;
    localparam int LPF_W    = LPF_LO_W + 1;
    localparam int CW       = PPL_W + 4;

    // Order of the four segments of a line or a frame
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_t;

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic [PPL_W-1:0]   ppl;
        logic [LPF_W-1:0]   lpf;
        logic [PORCH_W-1:0] hbp;
        logic [PORCH_W-1:0] hfp;
        logic [SYNC_W-1:0]  hsw;
        logic [PORCH_W-1:0] vbp;
        logic [PORCH_W-1:0] vfp;
        logic [SYNC_W-1:0]  vsw;
        logic               inv_p;
        logic               inv_l;
        logic               inv_f;
    } cfg_t;

endpackage

// File: rtl/lcdt_pixdiv.sv
// Module: pixel divider. While run is high it counts core cycles modulo
// max(div_in, 2). It gives a one-cycle tick at the end of each pixel period
// and a raw pixel clock that is high for the first half of the period.
// Assumes div_in is held steady while run is high.
module lcdt_pixdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div_in,
    output logic          tick,
    output logic          pclk_raw
);
    localparam logic [DW-1:0] ONE = DW'(1);
    localparam logic [DW-1:0] TWO = DW'(2);

    logic [DW-1:0] div_eff;
    logic [DW-1:0] cnt;

    // Force divisors below two up to two
    always_comb div_eff = (div_in < TWO) ? TWO : div_in;

    // Core-cycle counter inside one pixel period
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt >= div_eff - ONE)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

    assign tick     = run && (cnt == div_eff - ONE);
    assign pclk_raw = run && (cnt < (div_eff >> 1));

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("tick on consecutive cycles"); // R1

endmodule

// File: rtl/lcdt_seq.sv
// Module: four-segment sequencer. Each step moves one position through
// sync, back porch, active and front porch. last[k] is the final index of
// segment k. wrap flags the step that leaves the front porch.
// Assumes last is stable whenever clr is low.
module lcdt_seq
    import lcdt_pkg::*;
#(
    parameter int W = CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                step,
    input  logic [3:0][W-1:0]   last,
    output phase_t              phase,
    output logic [W-1:0]        pos,
    output logic                wrap
);
    logic at_end;

    assign at_end = (pos == last[phase]);
    assign wrap   = step && at_end && (phase == PH_FRONT);

    // Advance the position and move to the next segment at its end
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= PH_SYNC;
            pos   <= '0;
        end else if (step) begin
            if (at_end) begin
                phase <= phase_t'(phase + 2'd1);
                pos   <= '0;
            end else begin
                pos   <= pos + W'(1);
            end
        end
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= last[phase]) else $error("position past segment end"); // R4

    AST_WRAP_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (phase == PH_SYNC) && (pos == '0)) else $error("bad wrap"); // R4

endmodule

// File: rtl/lcd_raster_timing.sv
// Module: raster timing generator top. It captures the configuration while
// stopped, runs a horizontal and a vertical sequencer from the pixel tick,
// and drives the sync strobes, data enable and positions. Dropping the
// enable ends the run at the next frame boundary and raises done.
// Assumes enable is the last input set up before a start.
module lcd_raster_timing
    import lcdt_pkg::*;
#(
    parameter bit EXT_WIDTH = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raster_en,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [PPL_LO_W-1:0] cfg_width_lo,
    input  logic                cfg_width_top,
    input  logic [LPF_LO_W-1:0] cfg_height_lo,
    input  logic                cfg_height_top,
    input  logic [SYNC_W-1:0]   cfg_hsync,
    input  logic [PORCH_W-1:0]  cfg_hback,
    input  logic [PORCH_W-1:0]  cfg_hfront,
    input  logic [SYNC_W-1:0]   cfg_vsync,
    input  logic [PORCH_W-1:0]  cfg_vback,
    input  logic [PORCH_W-1:0]  cfg_vfront,
    input  logic                inv_pclk,
    input  logic                inv_lclk,
    input  logic                inv_fclk,
    output logic                pclk,
    output logic                lclk,
    output logic                fclk,
    output logic                de,
    output logic [CW-1:0]       h_pos,
    output logic [CW-1:0]       v_pos,
    output logic                done
);
    logic               running;
    logic               stop_pend;
    cfg_t               shadow;
    logic [PPL_W-1:0]   ppl_code;
    logic               tick, pclk_raw;
    logic [3:0][CW-1:0] h_last, v_last;
    phase_t             h_phase, v_phase;
    logic [CW-1:0]      h_cnt, v_cnt;
    logic               h_wrap, v_wrap;

    // Width code variant picked by parameter
    generate
        if (EXT_WIDTH) begin : g_wide
            assign ppl_code = {cfg_width_top, cfg_width_lo};
        end else begin : g_narrow
            logic unused_top;
            assign unused_top = cfg_width_top;
            assign ppl_code   = {1'b0, cfg_width_lo};
        end
    endgenerate

    // Capture configuration in every stopped cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (!running)
            shadow <= '{div: cfg_div, ppl: ppl_code,
                        lpf: {cfg_height_top, cfg_height_lo},
                        hbp: cfg_hback, hfp: cfg_hfront, hsw: cfg_hsync,
                        vbp: cfg_vback, vfp: cfg_vfront, vsw: cfg_vsync,
                        inv_p: inv_pclk, inv_l: inv_lclk, inv_f: inv_fclk};
    end

    // Run control: start on enable, stop at the end of a frame once asked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
            done      <= 1'b0;
        end else if (!running) begin
            if (raster_en) begin
                running   <= 1'b1;
                stop_pend <= 1'b0;
                done      <= 1'b0;
            end
        end else if (v_wrap && (stop_pend || !raster_en)) begin
            running   <= 1'b0;
            done      <= 1'b1;
        end else if (!raster_en) begin
            stop_pend <= 1'b1;
        end
    end

    // Final index of each line and frame segment
    always_comb begin
        h_last[PH_SYNC]  = CW'(shadow.hsw);
        h_last[PH_BACK]  = CW'(shadow.hbp);
        h_last[PH_ACT]   = {shadow.ppl, 4'hF};
        h_last[PH_FRONT] = CW'(shadow.hfp);
        v_last[PH_SYNC]  = CW'(shadow.vsw);
        v_last[PH_BACK]  = CW'(shadow.vbp);
        v_last[PH_ACT]   = CW'(shadow.lpf);
        v_last[PH_FRONT] = CW'(shadow.vfp);
    end

    lcdt_pixdiv #(.DW(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(running), .div_in(shadow.div),
        .tick(tick), .pclk_raw(pclk_raw)
    );

    lcdt_seq #(.W(CW)) u_hseq (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(tick),
        .last(h_last), .phase(h_phase), .pos(h_cnt), .wrap(h_wrap)
    );

    lcdt_seq #(.W(CW)) u_vseq (
        .clk(clk), .rst_n(rst_n), .clr(!running), .step(tick && h_wrap),
        .last(v_last), .phase(v_phase), .pos(v_cnt), .wrap(v_wrap)
    );

    assign de    = running && (h_phase == PH_ACT) && (v_phase == PH_ACT);
    assign h_pos = de ? h_cnt : '0;
    assign v_pos = de ? v_cnt : '0;
    assign pclk  = pclk_raw ^ shadow.inv_p;
    assign lclk  = (running && (h_phase == PH_SYNC)) ^ shadow.inv_l;
    assign fclk  = (running && (v_phase == PH_SYNC)) ^ shadow.inv_f;

    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running) else $error("done while running"); // R8

    AST_DONE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(v_wrap)) else $error("stop off frame edge"); // R8

    AST_DE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !de) else $error("de while idle"); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(shadow)) else $error("cfg moved"); // R9

endmodule

// File: tb/sim_lcd_raster_timing.sv
module sim_lcd_raster_timing;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raster_en = 1'b0;
    logic [7:0]  cfg_div = 8'd2;
    logic [5:0]  cfg_width_lo = 6'd0;
    logic        cfg_width_top = 1'b0;
    logic [9:0]  cfg_height_lo = 10'd3;
    logic        cfg_height_top = 1'b0;
    logic [5:0]  cfg_hsync = 6'd1;
    logic [7:0]  cfg_hback = 8'd2;
    logic [7:0]  cfg_hfront = 8'd1;
    logic [5:0]  cfg_vsync = 6'd0;
    logic [7:0]  cfg_vback = 8'd1;
    logic [7:0]  cfg_vfront = 8'd0;
    logic        inv_pclk = 1'b0, inv_lclk = 1'b0, inv_fclk = 1'b0;
    logic        pclk, lclk, fclk, de, done;
    logic [10:0] h_pos, v_pos;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    // results of one measured frame
    int r_cycles, r_de, r_lhi, r_fhi, r_prise, r_maxh, r_maxv, r_bad, r_line, r_f0;

    always #2.5 clk = ~clk;

    lcd_raster_timing u0 (
        .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .cfg_div(cfg_div),
        .cfg_width_lo(cfg_width_lo), .cfg_width_top(cfg_width_top),
        .cfg_height_lo(cfg_height_lo), .cfg_height_top(cfg_height_top),
        .cfg_hsync(cfg_hsync), .cfg_hback(cfg_hback), .cfg_hfront(cfg_hfront),
        .cfg_vsync(cfg_vsync), .cfg_vback(cfg_vback), .cfg_vfront(cfg_vfront),
        .inv_pclk(inv_pclk), .inv_lclk(inv_lclk), .inv_fclk(inv_fclk),
        .pclk(pclk), .lclk(lclk), .fclk(fclk), .de(de),
        .h_pos(h_pos), .v_pos(v_pos), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff_div();
        return (cfg_div < 8'd2) ? 2 : int'(cfg_div);
    endfunction
    function automatic int vis_w();
        return (int'({cfg_width_top, cfg_width_lo}) + 1) * 16;
    endfunction
    function automatic int vis_h();
        return int'({cfg_height_top, cfg_height_lo}) + 1;
    endfunction
    function automatic int line_px();
        return int'(cfg_hsync) + 1 + int'(cfg_hback) + 1 + vis_w() + int'(cfg_hfront) + 1;
    endfunction
    function automatic int frame_ln();
        return int'(cfg_vsync) + 1 + int'(cfg_vback) + 1 + vis_h() + int'(cfg_vfront) + 1;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Start, drop enable in the first cycle, measure until done
    task automatic run_frame(input bit poke);
        logic [7:0] keep_hfp;
        int pl = 0;
        int pp = 0;
        int l1 = -1;
        int n = 0;
        keep_hfp = cfg_hfront;
        r_de = 0; r_lhi = 0; r_fhi = 0; r_prise = 0; r_maxh = 0; r_maxv = 0;
        r_bad = 0; r_line = -1;
        raster_en = 1'b1;
        @(negedge clk);
        r_f0 = int'(fclk ^ inv_fclk);
        raster_en = 1'b0;
        if (poke) cfg_hfront = 8'd40;
        while (!done && n < 100000) begin
            if (de) begin
                r_de++;
                if (int'(h_pos) > r_maxh) r_maxh = int'(h_pos);
                if (int'(v_pos) > r_maxv) r_maxv = int'(v_pos);
            end else if (h_pos != 0 || v_pos != 0) r_bad++;
            if (lclk ^ inv_lclk) begin
                r_lhi++;
                if (pl == 0) begin
                    if (l1 < 0) l1 = n;
                    else if (r_line < 0) r_line = n - l1;
                end
            end
            if (fclk ^ inv_fclk) r_fhi++;
            if ((pclk ^ inv_pclk) && pp == 0) r_prise++;
            pl = int'(lclk ^ inv_lclk);
            pp = int'(pclk ^ inv_pclk);
            n++;
            @(negedge clk);
        end
        r_cycles = n;
        cfg_hfront = keep_hfp;
    endtask

    task automatic t_reset();
        check(de == 0 && done == 0, "R10 idle de/done", int'({de, done}), 0);
        check(h_pos == 0 && v_pos == 0, "R10 positions", int'(h_pos), 0);
        check({pclk, lclk, fclk} == 3'b000, "R10 clocks", int'({pclk, lclk, fclk}), 0);
    endtask

    task automatic t_basic();
        int f;
        f = eff_div() * line_px() * frame_ln();
        run_frame(1'b0);
        check(r_f0 == 1, "R5 frame clock at start", r_f0, 1);
        check(r_cycles == f, "R5 frame length", r_cycles, f);
        check(r_fhi == (int'(cfg_vsync) + 1) * line_px() * eff_div(), "R5 frame sync width",
              r_fhi, (int'(cfg_vsync) + 1) * line_px() * eff_div());
        check(r_line == line_px() * eff_div(), "R4 line period", r_line, line_px() * eff_div());
        check(r_lhi == frame_ln() * (int'(cfg_hsync) + 1) * eff_div(), "R4 line sync width",
              r_lhi, frame_ln() * (int'(cfg_hsync) + 1) * eff_div());
        check(r_de == vis_w() * vis_h() * eff_div(), "R6 de count", r_de, vis_w() * vis_h() * eff_div());
        check(r_maxh == vis_w() - 1, "R2 max column", r_maxh, vis_w() - 1);
        check(r_maxv == vis_h() - 1, "R3 max row", r_maxv, vis_h() - 1);
        check(r_bad == 0, "R6 positions zero outside de", r_bad, 0);
        check(r_prise == f / eff_div(), "R1 pixel clock edges", r_prise, f / eff_div());
        check(done == 1 && de == 0, "R8 done after stop", int'({done, de}), 2);
    endtask

    task automatic t_divisors();
        cfg_div = 8'd0; t_basic();
        cfg_div = 8'd1; t_basic();
        cfg_div = 8'd5; t_basic();
        cfg_div = 8'd2;
    endtask

    task automatic t_polarity();
        inv_pclk = 1'b1; inv_lclk = 1'b1; inv_fclk = 1'b1;
        repeat (2) @(negedge clk);
        check({pclk, lclk, fclk} == 3'b111, "R7 idle inverted", int'({pclk, lclk, fclk}), 7);
        cfg_div = 8'd3;
        t_basic();
        inv_pclk = 1'b0; inv_lclk = 1'b0; inv_fclk = 1'b0;
        cfg_div = 8'd2;
        repeat (2) @(negedge clk);
        check({pclk, lclk, fclk} == 3'b000, "R7 idle normal", int'({pclk, lclk, fclk}), 0);
    endtask

    task automatic t_wide();
        cfg_width_top = 1'b1; cfg_width_lo = 6'd1;
        t_basic();
        cfg_width_top = 1'b0; cfg_width_lo = 6'd0;
    endtask

    task automatic t_tall();
        cfg_hsync = 6'd0; cfg_hback = 8'd0; cfg_hfront = 8'd0;
        cfg_height_top = 1'b1; cfg_height_lo = 10'd2;
        t_basic();
        cfg_hsync = 6'd1; cfg_hback = 8'd2; cfg_hfront = 8'd1;
        cfg_height_top = 1'b0; cfg_height_lo = 10'd3;
    endtask

    task automatic t_frozen();
        int f;
        f = eff_div() * line_px() * frame_ln();
        run_frame(1'b1);
        check(r_cycles == f, "R9 running change ignored", r_cycles, f);
    endtask

    task automatic t_stop_edges();
        int f;
        f = eff_div() * line_px() * frame_ln();
        raster_en = 1'b1;
        @(negedge clk);
        check(done == 0, "R9 restart clears done", int'(done), 0);
        repeat (f - 1) @(negedge clk);
        raster_en = 1'b0;
        @(negedge clk);
        check(done == 1, "R8 stop in last frame cycle", int'(done), 1);
        repeat (3) @(negedge clk);
        check(de == 0 && (fclk ^ inv_fclk) == 0, "R8 idle after stop", int'({de, fclk}), 0);
        raster_en = 1'b1;
        @(negedge clk);
        repeat (f) @(negedge clk);
        raster_en = 1'b0;
        repeat (f - 1) @(negedge clk);
        check(done == 0, "R8 late stop runs extra frame", int'(done), 0);
        @(negedge clk);
        check(done == 1, "R8 late stop ends next frame", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_divisors();
        t_polarity();
        t_frozen();
        t_stop_edges();
        t_wide();
        t_tall();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule